// File: doc/BRIEF.md
# SDRAM Access Command Sequencer

This block sits on the controller side of an SDRAM interface. It converts one host request at a time into the command-pin patterns that the memory samples on each rising clock edge. A request names a bank, a row, a column and a direction. The sequencer keeps a record of which row is open in each bank. A request whose row is already open goes straight to a column command. A request to an idle bank first gets an activate. A request to a different row in an open bank first gets a precharge, then an activate. The row-to-column delay and the precharge recovery time are counted per bank, in clock cycles.

The host holds the request on a valid/ready handshake until the column command for it is issued. `req_ready` is high during the cycle whose decision is that column command. The command appears on the pins one clock edge later. Rows stay open after an access, so a run of requests that hit open rows produces one column command per clock. This holds for repeated requests to one bank and for requests that alternate between active banks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, and in every cycle with no request to act on, the pins carry NOP: cs_n=0, ras_n=1, cas_n=1, we_n=1. No bank is open after reset.
- R2: A column command has cs_n=0, ras_n=1, cas_n=0. we_n=1 marks a read and we_n=0 marks a write. `sd_addr` carries the column, zero-extended, and `sd_ba` carries the bank.
- R3: A request to a bank with no open row first drives an activate (cs_n=0, ras_n=0, cas_n=1, we_n=1), with the row on `sd_addr` and the bank on `sd_ba`.
- R4: The column command to a bank follows that bank's activate by exactly RCD_CYC cycles on the pins, with NOP in between.
- R5: A request whose row equals the open row of its bank drives its column command on the pins in the cycle after it is presented.
- R6: A request to a different row of an open bank drives a precharge first (cs_n=0, ras_n=0, cas_n=1, we_n=0, bank on `sd_ba`). The activate for the new row follows RP_CYC cycles later, and the column command comes RCD_CYC cycles after that.
- R7: `req_ready` is high only in the cycle whose decision is the column command for the held request, never during activate, precharge or wait cycles.
- R8: Back-to-back row-hit requests yield a column command in every clock cycle, both to one bank and alternating across banks.
- R9: A precharge and re-activate in one bank leaves the open rows of the other banks unchanged, so later requests to them still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Column command for the request is being issued |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row or column address |

## Verification
All command pins are registered. A decision made while a request is presented therefore reaches the pins one edge later. A row hit shows its column command in the first cycle after the request is presented. An idle bank shows the activate there, then RCD_CYC-1 NOP cycles, then the column command. A row miss adds a precharge and RP_CYC-1 NOP cycles in front of that. The bench drives inputs at the falling edge and samples the pins at each following falling edge, which is half a clock after the edge that updated them. It compares every sampled cycle against the sequence expected for the request type, and it checks that the handshake completes in exactly the cycle that precedes the column command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    STEP_IDLE   = 2'd0,
    STEP_OPEN   = 2'd1,
    STEP_CLOSE  = 2'd2,
    STEP_COLUMN = 2'd3
  } step_t;

  // pin order {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_OPEN  = 4'b0011;
  localparam logic [3:0] PINS_CLOSE = 4'b0010;
  localparam logic [3:0] PINS_RD    = 4'b0101;
  localparam logic [3:0] PINS_WR    = 4'b0100;

  function automatic step_t pick_step(input logic valid, input logic is_open,
                                      input logic row_hit, input logic settled);
    if (!valid || !settled) return STEP_IDLE;
    if (!is_open)           return STEP_OPEN;
    if (!row_hit)           return STEP_CLOSE;
    return STEP_COLUMN;
  endfunction

  function automatic logic [3:0] pins_for(input step_t s, input logic wr);
    case (s)
      STEP_OPEN:   return PINS_OPEN;
      STEP_CLOSE:  return PINS_CLOSE;
      STEP_COLUMN: return wr ? PINS_WR : PINS_RD;
      default:     return PINS_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W   = 12,
  parameter int RCD_CYC = 3,
  parameter int RP_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_col,
  input  logic [ROW_W-1:0] new_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             settled
);
  localparam int MAXW = (RCD_CYC > RP_CYC) ? RCD_CYC : RP_CYC;
  localparam int TW   = $clog2(MAXW + 1);

  logic [TW-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
      wait_q   <= '0;
    end else if (do_open) begin
      is_open  <= 1'b1;
      open_row <= new_row;
      wait_q   <= TW'(RCD_CYC - 1);
    end else if (do_close) begin
      is_open  <= 1'b0;
      wait_q   <= TW'(RP_CYC - 1);
    end else if (wait_q != '0) begin
      wait_q   <= wait_q - 1'b1;
    end
  end

  assign settled = (wait_q == '0);

  // independent age counters used only by the checks below
  logic [TW:0] since_open, since_close;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_open  <= (TW+1)'(MAXW);
      since_close <= (TW+1)'(MAXW);
    end else begin
      since_open  <= do_open  ? (TW+1)'(1) :
                     (since_open  < (TW+1)'(MAXW)) ? since_open  + 1'b1 : since_open;
      since_close <= do_close ? (TW+1)'(1) :
                     (since_close < (TW+1)'(MAXW)) ? since_close + 1'b1 : since_close;
    end
  end

  // R4
  rcd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> (since_open >= (TW+1)'(RCD_CYC)));
  // R6
  rp_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_open |-> (since_close >= (TW+1)'(RP_CYC)));
  // R6
  col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> is_open);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int RCD_CYC   = 3,
  parameter int RP_CYC    = 2,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);

  logic             bank_open    [NUM_BANKS];
  logic [ROW_W-1:0] bank_row     [NUM_BANKS];
  logic             bank_settled [NUM_BANKS];
  logic [NUM_BANKS-1:0] ev_open, ev_close, ev_col;

  step_t step;
  logic  sel_open, sel_hit, sel_settled;

  assign sel_open    = bank_open[req_bank];
  assign sel_hit     = (bank_row[req_bank] == req_row);
  assign sel_settled = bank_settled[req_bank];
  assign step        = pick_step(req_valid, sel_open, sel_hit, sel_settled);
  assign req_ready   = (step == STEP_COLUMN);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_me;
    assign hit_me      = (req_bank == BANK_W'(b));
    assign ev_open[b]  = hit_me && (step == STEP_OPEN);
    assign ev_close[b] = hit_me && (step == STEP_CLOSE);
    assign ev_col[b]   = hit_me && (step == STEP_COLUMN);

    sdram_bank_slot #(
      .ROW_W  (ROW_W),
      .RCD_CYC(RCD_CYC),
      .RP_CYC (RP_CYC)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_open (ev_open[b]),
      .do_close(ev_close[b]),
      .do_col  (ev_col[b]),
      .new_row (req_row),
      .is_open (bank_open[b]),
      .open_row(bank_row[b]),
      .settled (bank_settled[b])
    );
  end

  logic [ADDR_W-1:0] addr_d;
  always_comb begin
    case (step)
      STEP_OPEN:   addr_d = ADDR_W'(req_row);
      STEP_COLUMN: addr_d = ADDR_W'(req_col);
      default:     addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= PINS_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= pins_for(step, req_write);
      sd_ba   <= (step == STEP_IDLE) ? '0 : req_bank;
      sd_addr <= addr_d;
    end
  end

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_open, ev_close, ev_col}));
  // R7
  ready_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sd_cs_n && sd_ras_n && !sd_cas_n));
  // R1
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int TRCD = 3;
  localparam int TRP  = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_PRE = 4'b0010,
                         C_RD  = 4'b0101, C_WR  = 4'b0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_seq #(.RCD_CYC(TRCD), .RP_CYC(TRP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 row hit, 1 idle bank, 2 row miss
  task automatic run_req(input int b, input int row, input int col, input bit wr,
                         input int kind, input string tag);
    int ofs = (kind == 2) ? TRP : 0;
    int exp_len = (kind == 0) ? 1 : ofs + TRCD + 1;
    int n = 0;
    bit acc = 0;
    int acc_idx = -1;
    int bad_idx = -1;
    logic [3:0] bad_got = '0, bad_exp = '0;
    logic [3:0] got, exp;
    req_valid = 1; req_bank = 2'(b); req_row = 12'(row); req_col = 9'(col); req_write = wr;
    while (!acc && n < 40) begin
      #1;
      if (req_ready) begin acc = 1; acc_idx = n; end
      @(posedge clk); @(negedge clk);
      got = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (kind == 2 && n == 0)        exp = C_PRE;
      else if (kind >= 1 && n == ofs) exp = C_ACT;
      else if (n == exp_len - 1)      exp = wr ? C_WR : C_RD;
      else                            exp = C_NOP;
      if (got != exp && bad_idx < 0) begin bad_idx = n; bad_got = got; bad_exp = exp; end
      if (kind == 2 && n == 0)
        check(sd_ba == 2'(b), {tag, " R6 precharge bank"}, sd_ba, b);
      if (kind >= 1 && n == ofs)
        check(sd_addr == 12'(row) && sd_ba == 2'(b), {tag, " R3 activate row/bank"},
              {sd_ba, sd_addr}, {2'(b), 12'(row)});
      if (exp != C_NOP && exp != C_ACT && exp != C_PRE)
        check(sd_addr == 12'(col) && sd_ba == 2'(b), {tag, " R2 column addr/bank"},
              {sd_ba, sd_addr}, {2'(b), 12'(col)});
      n++;
    end
    req_valid = 0;
    check(bad_idx < 0, {tag, " command sequence"}, bad_got, bad_exp);
    check(acc_idx == exp_len - 1, {tag, " R7 ready cycle"}, acc_idx, exp_len - 1);
  endtask

  task automatic t_reset();
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset pins",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    repeat (3) @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 idle pins",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
  endtask

  task automatic t_open_and_hit();
    run_req(0, 5, 'h12, 0, 1, "R3 R4 idle bank read");
    run_req(0, 5, 'h07, 1, 0, "R5 hit write");
  endtask

  task automatic t_interleave();
    run_req(1, 9, 'h20, 0, 1, "R3 R4 second bank");
    run_req(0, 5, 'h01, 0, 0, "R8 alt bank0");
    run_req(1, 9, 'h02, 1, 0, "R8 alt bank1");
    run_req(0, 5, 'h03, 1, 0, "R8 alt bank0 again");
    run_req(0, 5, 'h1ff, 0, 0, "R8 same bank");
  endtask

  task automatic t_miss();
    run_req(0, 6, 'h44, 1, 2, "R6 row miss");
    run_req(1, 9, 'h10, 0, 0, "R9 other bank kept");
    run_req(0, 6, 'h45, 0, 0, "R9 new row open");
    run_req(3, 'hfff, 'h0, 0, 1, "R3 R4 top bank max row");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_open_and_hit();
    t_interleave();
    t_miss();
    repeat (2) @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 idle after traffic",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule